// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the device side of a NOR-style flash command interface. A host issues bus write cycles that carry a word address and a 16-bit data value. The low byte of each written value is decoded as a command. Some commands take effect in one cycle, and others need a setup cycle followed by a confirm or data cycle. Read cycles return one of three views, chosen by the last read-mode command: the storage array, an identifier pair, or the status register.

Word program and block erase run on a simulated write state machine. An erase visits every word of the addressed block, one word per clock, and sets it to all ones. A program waits a configurable number of busy cycles, then stores the old word ANDed with the new data. A running operation can be suspended, which leaves the array readable, and then resumed. The array is split into small boot blocks, small parameter blocks and large main blocks. The boot blocks can be locked against change. A missing programming supply, a locked block or a malformed command sequence each leave sticky error bits in the status register.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is ready, reads return array contents, and a status read returns 0080h. The array powers up with every word at FFFFh.
- R2: Command byte FFh selects array reads, 90h selects identifier reads and 70h selects status reads. The mode holds until another mode-changing command is written. In identifier mode, word 0 returns MFR_CODE, word 1 returns DEV_CODE, and any other word returns 0000h.
- R3: Setup byte 40h or 10h, followed by a data write, stores the old word ANDed with the data at the data write's address. `ready` stays low for exactly PROG_CYCLES clocks.
- R4: Byte 20h followed by D0h at an address in the same block sets every word of that block to FFFFh and leaves the words just outside it unchanged. The blocks, from address 0, are N_BOOT boot and N_PARAM parameter blocks of SMALL_WORDS each, then N_MAIN main blocks of MAIN_WORDS each.
- R5: If the second cycle of an erase is not D0h, or falls in a different block, status bits 5 and 4 are set and the array is unchanged.
- R6: If `vpp_ok` is low at the second cycle of a program or erase, status bit 3 is set along with bit 4 (program) or bit 5 (erase), and the array is unchanged.
- R7: While `boot_lock` is high, a program or erase aimed at a boot block sets status bit 1 along with bit 4 or bit 5, and the array is unchanged. Parameter and main blocks stay writable.
- R8: While an operation runs, `ready` is low and reads return the status register with bit 7 clear, whatever the selected mode. Only B0h and 70h are acted on, so a FFh written while busy leaves status mode selected.
- R9: B0h during an erase stops it, raises `ready` and sets status bit 6. B0h during a program does the same with status bit 2. The array can be read while the operation is suspended. D0h resumes the operation, which then completes.
- R10: Error bits 5, 4, 3 and 1 stay set through later commands and operations. Only command 50h or reset clears them.
- R11: `rdata` shows the selected view for the address presented one clock earlier, so back-to-back reads of different addresses return their own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write cycle strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 16 | Write data; low byte is the command code |
| vpp_ok | input | 1 | Programming supply is within range |
| boot_lock | input | 1 | High protects the boot blocks |
| rdata | output | 16 | Read data for the address of the previous clock |
| ready | output | 1 | High when no operation is running |

## Verification
The bench builds the block with 8-word small blocks, 32-word main blocks, six main blocks and 12 program cycles, which gives a 256-word array. With these values a full erase walk takes only a few dozen clocks. A suspend can land in the middle of both an erase and a program, and the words on both sides of every block boundary are easy to reach. The small array also means random programs and erases revisit the same words often, so the bench model's AND behaviour on reprogrammed words gets regular use.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_STATUS} rd_mode_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ERASE, SEQ_PROG} seq_e;
  typedef enum logic [1:0] {OP_NONE, OP_ERASE_RUN, OP_PROG_RUN} wsm_op_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_PROG       = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT   = 8'h10;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
endpackage

// File: rtl/flash_blk_map.sv
module flash_blk_map #(
  parameter int ADDR_W      = 11,
  parameter int BLK_W       = 5,
  parameter int SMALL_WORDS = 16,
  parameter int MAIN_WORDS  = 128,
  parameter int N_BOOT      = 2,
  parameter int N_PARAM     = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  blk_idx,
  output logic [ADDR_W-1:0] blk_base,
  output logic [ADDR_W-1:0] blk_last,
  output logic              is_boot
);
  localparam int SMALL_LG  = $clog2(SMALL_WORDS);
  localparam int MAIN_LG   = $clog2(MAIN_WORDS);
  localparam int BOOT_END  = N_BOOT * SMALL_WORDS;
  localparam int SMALL_END = (N_BOOT + N_PARAM) * SMALL_WORDS;

  logic [ADDR_W-1:0] main_off;

  always_comb begin
    main_off = addr - ADDR_W'(SMALL_END);
    is_boot  = 32'(addr) < BOOT_END;
    if (32'(addr) < SMALL_END) begin
      blk_idx  = BLK_W'(addr >> SMALL_LG);
      blk_base = addr & ~ADDR_W'(SMALL_WORDS - 1);
      blk_last = blk_base | ADDR_W'(SMALL_WORDS - 1);
    end else begin
      blk_idx  = BLK_W'(N_BOOT + N_PARAM) + BLK_W'(main_off >> MAIN_LG);
      blk_base = ADDR_W'(SMALL_END) + (main_off & ~ADDR_W'(MAIN_WORDS - 1));
      blk_last = blk_base + ADDR_W'(MAIN_WORDS - 1);
    end
  end
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode import flash_cmd_pkg::*; #(
  parameter int BLK_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       cmd,
  input  logic [BLK_W-1:0] blk_idx,
  input  logic             is_boot,
  input  logic             vpp_ok,
  input  logic             boot_lock,
  input  logic             run,
  input  logic             susp,
  output rd_mode_e         mode,
  output logic             e_ers,
  output logic             e_prg,
  output logic             e_vpp,
  output logic             e_prot,
  output logic             start_erase,
  output logic             start_prog,
  output logic             suspend_req,
  output logic             resume_req
);
  seq_e             seq, seq_n;
  rd_mode_e         mode_n;
  logic [BLK_W-1:0] setup_blk, setup_blk_n;
  logic             e_ers_n, e_prg_n, e_vpp_n, e_prot_n;

  always_comb begin
    mode_n      = mode;
    seq_n       = seq;
    setup_blk_n = setup_blk;
    e_ers_n     = e_ers;
    e_prg_n     = e_prg;
    e_vpp_n     = e_vpp;
    e_prot_n    = e_prot;
    start_erase = 1'b0;
    start_prog  = 1'b0;
    suspend_req = 1'b0;
    resume_req  = 1'b0;
    if (wr_en) begin
      if (run) begin
        if (cmd == CMD_SUSPEND) begin
          suspend_req = 1'b1;
          mode_n      = RD_STATUS;
        end else if (cmd == CMD_READ_STAT) begin
          mode_n = RD_STATUS;
        end
      end else begin
        case (seq)
          SEQ_ERASE: begin
            seq_n  = SEQ_IDLE;
            mode_n = RD_STATUS;
            if (cmd != CMD_CONFIRM || blk_idx != setup_blk) begin
              e_ers_n = 1'b1;
              e_prg_n = 1'b1;
            end else if (!vpp_ok) begin
              e_vpp_n = 1'b1;
              e_ers_n = 1'b1;
            end else if (is_boot && boot_lock) begin
              e_prot_n = 1'b1;
              e_ers_n  = 1'b1;
            end else begin
              start_erase = 1'b1;
            end
          end
          SEQ_PROG: begin
            seq_n  = SEQ_IDLE;
            mode_n = RD_STATUS;
            if (!vpp_ok) begin
              e_vpp_n = 1'b1;
              e_prg_n = 1'b1;
            end else if (is_boot && boot_lock) begin
              e_prot_n = 1'b1;
              e_prg_n  = 1'b1;
            end else begin
              start_prog = 1'b1;
            end
          end
          default: begin
            case (cmd)
              CMD_READ_ARRAY: mode_n = RD_ARRAY;
              CMD_READ_ID:    mode_n = RD_IDENT;
              CMD_READ_STAT:  mode_n = RD_STATUS;
              CMD_CLEAR: begin
                e_ers_n  = 1'b0;
                e_prg_n  = 1'b0;
                e_vpp_n  = 1'b0;
                e_prot_n = 1'b0;
              end
              CMD_ERASE: if (!susp) begin
                seq_n       = SEQ_ERASE;
                setup_blk_n = blk_idx;
                mode_n      = RD_STATUS;
              end
              CMD_PROG, CMD_PROG_ALT: if (!susp) begin
                seq_n  = SEQ_PROG;
                mode_n = RD_STATUS;
              end
              CMD_CONFIRM: if (susp) begin
                resume_req = 1'b1;
                mode_n     = RD_STATUS;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= RD_ARRAY;
      seq       <= SEQ_IDLE;
      setup_blk <= '0;
      e_ers     <= 1'b0;
      e_prg     <= 1'b0;
      e_vpp     <= 1'b0;
      e_prot    <= 1'b0;
    end else begin
      mode      <= mode_n;
      seq       <= seq_n;
      setup_blk <= setup_blk_n;
      e_ers     <= e_ers_n;
      e_prg     <= e_prg_n;
      e_vpp     <= e_vpp_n;
      e_prot    <= e_prot_n;
    end
  end
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm import flash_cmd_pkg::*; #(
  parameter int ADDR_W      = 11,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_erase,
  input  logic              start_prog,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic [ADDR_W-1:0] blk_base,
  input  logic [ADDR_W-1:0] blk_last,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] old_data,
  output logic              run,
  output logic              susp_erase,
  output logic              susp_prog,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] prog_addr
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  wsm_op_e           op;
  logic              susp;
  logic [ADDR_W-1:0] ptr, last;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] pdata;
  logic              step_done;

  assign step_done  = (op == OP_ERASE_RUN) ? (ptr == last) : (cnt == '0);
  assign mem_we     = run && !suspend_req && ((op == OP_ERASE_RUN) || (cnt == '0));
  assign mem_waddr  = (op == OP_ERASE_RUN) ? ptr : prog_addr;
  assign mem_wdata  = (op == OP_ERASE_RUN) ? {WORD_W{1'b1}} : (old_data & pdata);
  assign susp_erase = susp && (op == OP_ERASE_RUN);
  assign susp_prog  = susp && (op == OP_PROG_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      op        <= OP_NONE;
      run       <= 1'b0;
      susp      <= 1'b0;
      ptr       <= '0;
      last      <= '0;
      cnt       <= '0;
      pdata     <= '0;
      prog_addr <= '0;
    end else if (start_erase) begin
      op   <= OP_ERASE_RUN;
      run  <= 1'b1;
      ptr  <= blk_base;
      last <= blk_last;
    end else if (start_prog) begin
      op        <= OP_PROG_RUN;
      run       <= 1'b1;
      prog_addr <= addr;
      pdata     <= wdata;
      cnt       <= CNT_W'(PROG_CYCLES - 1);
    end else if (suspend_req) begin
      run  <= 1'b0;
      susp <= 1'b1;
    end else if (resume_req) begin
      run  <= 1'b1;
      susp <= 1'b0;
    end else if (run) begin
      if (step_done) begin
        run <= 1'b0;
        op  <= OP_NONE;
      end else if (op == OP_ERASE_RUN) begin
        ptr <= ptr + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {DATA_W{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q_a <= mem[raddr_a];
    q_b <= mem[raddr_b];
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import flash_cmd_pkg::*; #(
  parameter int SMALL_WORDS       = 16,
  parameter int MAIN_WORDS        = 128,
  parameter int N_BOOT            = 2,
  parameter int N_PARAM           = 6,
  parameter int N_MAIN            = 15,
  parameter int PROG_CYCLES       = 64,
  parameter logic [15:0] MFR_CODE = 16'h001C,
  parameter logic [15:0] DEV_CODE = 16'h2A7E,
  localparam int TOTAL_WORDS      = (N_BOOT + N_PARAM) * SMALL_WORDS + N_MAIN * MAIN_WORDS,
  localparam int ADDR_W           = $clog2(TOTAL_WORDS),
  localparam int N_BLK            = N_BOOT + N_PARAM + N_MAIN,
  localparam int BLK_W            = $clog2(N_BLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              vpp_ok,
  input  logic              boot_lock,
  output logic [15:0]       rdata,
  output logic              ready
);
  logic [BLK_W-1:0]  blk_idx;
  logic [ADDR_W-1:0] blk_base, blk_last, prog_addr, mem_waddr;
  logic              is_boot;
  rd_mode_e          mode;
  logic              e_ers, e_prg, e_vpp, e_prot;
  logic              start_erase, start_prog, suspend_req, resume_req;
  logic              run, susp_erase, susp_prog, mem_we;
  logic [WORD_W-1:0] mem_wdata, arr_q, old_q, aux_q, id_val;
  logic [7:0]        status;
  logic              sel_arr;

  flash_blk_map #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .SMALL_WORDS(SMALL_WORDS),
    .MAIN_WORDS(MAIN_WORDS), .N_BOOT(N_BOOT), .N_PARAM(N_PARAM)
  ) u_map (
    .addr(addr), .blk_idx(blk_idx), .blk_base(blk_base),
    .blk_last(blk_last), .is_boot(is_boot)
  );

  flash_cmd_decode #(.BLK_W(BLK_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(wdata[7:0]),
    .blk_idx(blk_idx), .is_boot(is_boot), .vpp_ok(vpp_ok),
    .boot_lock(boot_lock), .run(run), .susp(susp_erase | susp_prog),
    .mode(mode), .e_ers(e_ers), .e_prg(e_prg), .e_vpp(e_vpp),
    .e_prot(e_prot), .start_erase(start_erase), .start_prog(start_prog),
    .suspend_req(suspend_req), .resume_req(resume_req)
  );

  flash_wsm #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_wsm (
    .clk(clk), .rst(rst), .start_erase(start_erase), .start_prog(start_prog),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .blk_base(blk_base), .blk_last(blk_last), .addr(addr), .wdata(wdata),
    .old_data(old_q), .run(run), .susp_erase(susp_erase),
    .susp_prog(susp_prog), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .prog_addr(prog_addr)
  );

  flash_array #(.ADDR_W(ADDR_W), .DATA_W(WORD_W), .DEPTH(TOTAL_WORDS)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(addr), .raddr_b(prog_addr), .q_a(arr_q), .q_b(old_q)
  );

  assign status = {~run, susp_erase, e_ers, e_prg, e_vpp, susp_prog, e_prot, 1'b0};

  always_comb begin
    if (addr == '0)                 id_val = MFR_CODE;
    else if (addr == ADDR_W'(1))    id_val = DEV_CODE;
    else                            id_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_arr <= 1'b1;
      aux_q   <= '0;
    end else begin
      sel_arr <= !run && (mode == RD_ARRAY);
      aux_q   <= (run || mode == RD_STATUS) ? {8'h00, status} : id_val;
    end
  end

  assign rdata = sel_arr ? arr_q : aux_q;
  assign ready = ~run;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [7:0]  cmd_byte,
  input logic        ready,
  input logic [15:0] rdata,
  input logic        run,
  input logic        susp_any,
  input logic        start_any,
  input logic        start_erase,
  input logic [3:0]  err_vec
);
  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ready);

  assert_busy_reads_status_R8: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (rdata[15:7] == 9'd0));

  assert_suspend_is_ready_R9: assert property (@(posedge clk) disable iff (rst)
    susp_any |-> ready);

  assert_run_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(start_any));

  assert_erase_needs_confirm_R4: assert property (@(posedge clk) disable iff (rst)
    start_erase |-> (wr_en && cmd_byte == 8'hD0));

  assert_errors_cleared_by_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(err_vec) != 4'd0 && err_vec == 4'd0) |-> $past(wr_en && cmd_byte == 8'h50));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_byte(wdata[7:0]),
  .ready(ready), .rdata(rdata), .run(run),
  .susp_any(susp_erase | susp_prog),
  .start_any(start_erase | start_prog | resume_req),
  .start_erase(start_erase),
  .err_vec({e_ers, e_prg, e_vpp, e_prot})
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int SW = 8, MW = 32, NB = 2, NP = 6, NM = 6, PC = 12;
  localparam int TOT = (NB + NP) * SW + NM * MW;
  localparam int AW = $clog2(TOT);
  localparam int SMALL_END = (NB + NP) * SW;
  localparam logic [15:0] MFR = 16'h001C, DEV = 16'h2A7E;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, vpp_ok = 1'b1, boot_lock = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic ready;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [15:0] ref_mem [TOT];

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.SMALL_WORDS(SW), .MAIN_WORDS(MW), .N_BOOT(NB), .N_PARAM(NP),
    .N_MAIN(NM), .PROG_CYCLES(PC), .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .vpp_ok(vpp_ok), .boot_lock(boot_lock), .rdata(rdata), .ready(ready));

  function automatic int base_of(int a);
    if (a < SMALL_END) return a - (a % SW);
    return SMALL_END + ((a - SMALL_END) / MW) * MW;
  endfunction
  function automatic int size_of(int a);
    return (a < SMALL_END) ? SW : MW;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input int a, output logic [15:0] q);
    addr = AW'(a);
    @(negedge clk); q = rdata;
  endtask
  task automatic rd_arr(input int a, output logic [15:0] q);
    wr(a, 16'h00FF); rd(a, q);
  endtask
  task automatic rd_stat(output logic [15:0] q);
    wr(0, 16'h0070); rd(0, q);
  endtask
  task automatic wait_ready();
    for (int i = 0; i < 1000 && !ready; i++) @(negedge clk);
  endtask
  task automatic prog(input int a, input logic [15:0] d, input logic [7:0] setup);
    wr(a, {8'h00, setup}); wr(a, d); wait_ready();
    ref_mem[a] = ref_mem[a] & d;
  endtask
  task automatic erase(input int a);
    wr(a, 16'h0020); wr(a, 16'h00D0); wait_ready();
    for (int i = 0; i < size_of(a); i++) ref_mem[base_of(a) + i] = 16'hFFFF;
  endtask
  task automatic clear_err();
    wr(0, 16'h0050);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    int cnt;
    void'($urandom(32'd4242));
    for (int i = 0; i < TOT; i++) ref_mem[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 ready after reset", {15'd0, ready}, 16'd1);
    rd(5, q);  chk("R1 array mode after reset", q, 16'hFFFF);
    rd_stat(q); chk("R1 status after reset", q, 16'h0080);

    // R2 / R11 identifier mode
    wr(0, 16'h0090);
    rd(0, q); chk("R2 manufacturer code", q, MFR);
    rd(1, q); chk("R11 back-to-back read of device code", q, DEV);
    rd(2, q); chk("R2 other identifier offset", q, 16'h0000);
    rd(0, q); chk("R2 identifier mode persists", q, MFR);
    wr(3, 16'h00FF); rd(3, q); chk("R2 back to array mode", q, 16'hFFFF);

    // R3 program with primary setup, busy length
    wr(70, 16'h0040); wr(70, 16'h1234);
    cnt = 0;
    while (!ready && cnt < 1000) begin cnt++; @(negedge clk); end
    ref_mem[70] = 16'h1234;
    chk("R3 busy cycles", 16'(cnt), 16'(PC));
    rd_arr(70, q); chk("R3 program data", q, ref_mem[70]);

    // R3 alternate setup + R8 busy behaviour
    wr(70, 16'h0010); wr(70, 16'hFF0F);
    chk("R8 ready low while busy", {15'd0, ready}, 16'd0);
    wr(70, 16'h00FF);
    rd(70, q); chk("R8 busy read gives status", q, 16'h0000);
    wait_ready();
    ref_mem[70] = ref_mem[70] & 16'hFF0F;
    rd(70, q); chk("R8 FF ignored while busy", q, 16'h0080);
    rd_arr(70, q); chk("R3 alternate setup ANDs data", q, 16'h1204);

    // R4 erase with boundary words
    prog(95, 16'h0A0A, 8'h40); prog(96, 16'h0B0B, 8'h40);
    prog(127, 16'h0C0C, 8'h40); prog(128, 16'h0D0D, 8'h40);
    erase(110);
    rd_arr(96, q);  chk("R4 main block first word", q, 16'hFFFF);
    rd_arr(127, q); chk("R4 main block last word", q, 16'hFFFF);
    rd_arr(95, q);  chk("R4 word below block kept", q, 16'h0A0A);
    rd_arr(128, q); chk("R4 word above block kept", q, 16'h0D0D);
    prog(16, 16'h1111, 8'h40); prog(23, 16'h2222, 8'h40); prog(24, 16'h3333, 8'h40);
    erase(20);
    rd_arr(16, q); chk("R4 parameter block first", q, 16'hFFFF);
    rd_arr(23, q); chk("R4 parameter block last", q, 16'hFFFF);
    rd_arr(24, q); chk("R4 next parameter block kept", q, 16'h3333);

    // R5 sequence errors, R10 sticky and clear
    prog(100, 16'h5555, 8'h40);
    wr(100, 16'h0020); wr(100, 16'h00FF);
    rd_stat(q); chk("R5 bad confirm byte", q, 16'h00B0);
    rd_arr(100, q); chk("R5 array unchanged", q, 16'h5555);
    clear_err(); rd_stat(q); chk("R10 clear command", q, 16'h0080);
    wr(100, 16'h0020); wr(140, 16'h00D0);
    rd_stat(q); chk("R5 confirm in other block", q, 16'h00B0);
    rd_arr(100, q); chk("R5 array unchanged other block", q, 16'h5555);
    prog(101, 16'h7777, 8'h40);
    rd_stat(q); chk("R10 errors sticky across program", q, 16'h00B0);
    rd_arr(101, q); chk("R10 program still works", q, 16'h7777);
    clear_err();

    // R6 supply fault
    vpp_ok = 1'b0;
    wr(102, 16'h0040); wr(102, 16'h0000);
    rd_stat(q); chk("R6 program supply fault", q, 16'h0098);
    rd_arr(102, q); chk("R6 word unchanged", q, 16'hFFFF);
    clear_err();
    wr(100, 16'h0020); wr(100, 16'h00D0);
    rd_stat(q); chk("R6 erase supply fault", q, 16'h00A8);
    rd_arr(100, q); chk("R6 block unchanged", q, 16'h5555);
    clear_err(); vpp_ok = 1'b1;

    // R7 boot lock
    boot_lock = 1'b1;
    wr(3, 16'h0040); wr(3, 16'h0000);
    rd_stat(q); chk("R7 program locked boot", q, 16'h0092);
    clear_err();
    wr(9, 16'h0020); wr(9, 16'h00D0);
    rd_stat(q); chk("R7 erase locked boot", q, 16'h00A2);
    clear_err();
    prog(20, 16'h4444, 8'h40);
    rd_stat(q); chk("R7 parameter block writable", q, 16'h0080);
    rd_arr(3, q); chk("R7 boot word unchanged", q, 16'hFFFF);
    boot_lock = 1'b0;
    prog(3, 16'h6666, 8'h40);
    rd_arr(3, q); chk("R7 boot writable when unlocked", q, 16'h6666);

    // R9 erase suspend / resume
    prog(200, 16'h1357, 8'h40); prog(223, 16'h2468, 8'h40);
    wr(210, 16'h0020); wr(210, 16'h00D0);
    repeat (4) @(negedge clk);
    wr(0, 16'h00B0);
    rd(0, q); chk("R9 erase suspended status", q, 16'h00C0);
    rd_arr(192, q); chk("R9 erased word during suspend", q, 16'hFFFF);
    rd_arr(223, q); chk("R9 pending word during suspend", q, 16'h2468);
    wr(0, 16'h00D0);
    chk("R9 busy after resume", {15'd0, ready}, 16'd0);
    wait_ready();
    for (int i = 192; i < 224; i++) ref_mem[i] = 16'hFFFF;
    rd_arr(223, q); chk("R9 erase completes", q, 16'hFFFF);

    // R9 program suspend / resume
    prog(230, 16'h5A5A, 8'h40);
    wr(230, 16'h0040); wr(230, 16'h0FF0);
    wr(0, 16'h00B0);
    rd(0, q); chk("R9 program suspended status", q, 16'h0084);
    rd_arr(230, q); chk("R9 old word during suspend", q, 16'h5A5A);
    wr(0, 16'h00D0); wait_ready();
    ref_mem[230] = 16'h0A50;
    rd_arr(230, q); chk("R9 program completes", q, 16'h0A50);

    // random mix against the bench model
    for (int it = 0; it < 60; it++) begin
      int a;
      int sel;
      logic [15:0] d;
      a   = int'($urandom % TOT);
      sel = int'($urandom % 8);
      d   = 16'($urandom);
      if (sel == 0) begin
        erase(a);
        rd_arr(base_of(a) + size_of(a) - 1, q);
        chk("R4 random erase", q, 16'hFFFF);
      end else if (sel < 4) begin
        prog(a, d, (sel == 1) ? 8'h10 : 8'h40);
        rd_arr(a, q);
        chk("R3 random program", q, ref_mem[a]);
      end else begin
        rd_arr(a, q);
        chk("R11 random read", q, ref_mem[a]);
      end
    end
    rd_stat(q); chk("R10 no errors after random mix", q, 16'h0080);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule